// File: doc/BRIEF.md
# Push-Button Single Pulse Generator

This block turns a manual push-button level into exactly one clock-aligned strobe per press. A free-running clock drives it and a clean button level enters it; however long the button is held, the output goes high for one whole clock period and then stays low until the button has been let go and pressed again.

The button level passes through a chain of edge-triggered sampling stages. The control logic watches the two newest stages. When the newer stage reads pressed and the older stage still reads released, the control raises a fire strobe, and the datapath loads that strobe into a registered output. All storage clears asynchronously on an active-low reset, so the output is low immediately and needs no clock edge to get there. The design can add extra sampling stages to delay the strobe, but the default is the plain two-stage cascade.

Top module: `press_pulse_gen`

## Requirements
- R1: While rstN is low, pulseOut is 0 regardless of buttonIn and the clock.
- R2: One press (buttonIn sampled high on one or more consecutive rising edges) yields exactly one pulse, whether it is held for 1 cycle or for 50.
- R3: Every pulse on pulseOut is high for exactly one clock period, from one rising edge to the next.
- R4: With the default two stages, if buttonIn is first sampled high at rising edge k, pulseOut rises at edge k+1 and falls at edge k+2.
- R5: A new pulse needs buttonIn to be sampled low on at least one rising edge after the previous press. A low glitch that falls between two edges does not re-arm the block.
- R6: If buttonIn is already high when rstN is released, the block treats this as a press and emits exactly one pulse.
- R7: Driving rstN low while pulseOut is high clears pulseOut at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; all stages update on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset of every stage and of the output |
| buttonIn | input | 1 | Clean push-button level, 1 while pressed |
| pulseOut | output | 1 | Registered strobe, high for one clock period per press |

## Verification
The button is driven as a single-cycle tap, as a long hold, as a string of taps separated by one-cycle gaps, and as a hold with a short low glitch that lands between edges. The tap and the hold show that the pulse count and width do not depend on how long the button is held. The gap run shows that one low sample is enough to re-arm the block, and the glitch run shows that a release that is never sampled does not re-arm it. Two reset cases, a press held across reset release and a reset asserted during a live pulse, check that start-up produces a single pulse and that the clear is asynchronous.

// File: rtl/press_pulse_pkg.sv
`timescale 1ns/1ps
package press_pulse_pkg;
  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic fire;   // load a one-cycle pulse into the output register
  } pulseCtl_t;
endpackage

// File: rtl/press_pulse_datapath.sv
`timescale 1ns/1ps
module press_pulse_datapath
  import press_pulse_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      buttonIn,
  input  pulseCtl_t ctl,
  output logic      newTap,
  output logic      oldTap,
  output logic      pulseOut
);
  localparam int NEW_IDX = STAGES - 2;
  localparam int OLD_IDX = STAGES - 1;

  logic [STAGES-1:0] stageQ;
  logic              pulseQ;

  // Cascade of edge-triggered sampling stages, each with asynchronous clear.
  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[gi] <= 1'b0;
          else       stageQ[gi] <= buttonIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[gi] <= 1'b0;
          else       stageQ[gi] <= stageQ[gi-1];
        end
      end
    end
  endgenerate

  // Registered output strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseQ <= 1'b0;
    else       pulseQ <= ctl.fire;
  end

  assign newTap   = stageQ[NEW_IDX];
  assign oldTap   = stageQ[OLD_IDX];
  assign pulseOut = pulseQ;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ); // R3

  AST_RISE_AFTER_PRESS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseQ) |-> stageQ[OLD_IDX]); // R4

  AST_HOLD_NO_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    (stageQ[OLD_IDX] && $past(stageQ[OLD_IDX])) |-> !pulseQ); // R2
endmodule

// File: rtl/press_pulse_control.sv
`timescale 1ns/1ps
module press_pulse_control
  import press_pulse_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      newTap,
  input  logic      oldTap,
  output pulseCtl_t ctl
);
  // Fire only on the cycle the newer stage has seen the press and the
  // older stage still holds the released level.
  always_comb begin
    ctl      = '0;
    ctl.fire = newTap & ~oldTap;
  end

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |=> !ctl.fire); // R3

  AST_REARM_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |-> !oldTap); // R5
endmodule

// File: rtl/press_pulse_gen.sv
`timescale 1ns/1ps
module press_pulse_gen
  import press_pulse_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic buttonIn,
  output logic pulseOut
);
  pulseCtl_t ctl;
  logic      newTap;
  logic      oldTap;

  press_pulse_datapath #(.STAGES(STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .buttonIn (buttonIn),
    .ctl      (ctl),
    .newTap   (newTap),
    .oldTap   (oldTap),
    .pulseOut (pulseOut)
  );

  press_pulse_control u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .newTap (newTap),
    .oldTap (oldTap),
    .ctl    (ctl)
  );
endmodule

// File: tb/sim_press_pulse_gen.sv
`timescale 1ns/1ps
module sim_press_pulse_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic buttonIn = 1'b0;
  logic pulseOut;

  int testsRun = 0;
  int testsFailed = 0;
  int rises = 0;
  int highCycles = 0;
  int curWidth = 0;
  int maxWidth = 0;
  logic prevPulse = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  press_pulse_gen u0 (
    .clk      (clk),
    .rstN     (rstN),
    .buttonIn (buttonIn),
    .pulseOut (pulseOut)
  );

  // Monitor samples the output at the falling edge, away from updates.
  always @(negedge clk) begin
    if (pulseOut) begin
      highCycles <= highCycles + 1;
      curWidth   <= curWidth + 1;
      if (curWidth + 1 > maxWidth) maxWidth <= curWidth + 1;
      if (!prevPulse) rises <= rises + 1;
    end else begin
      curWidth <= 0;
    end
    prevPulse <= pulseOut;
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic clearCounts();
    @(negedge clk);
    #0.1;
    rises = 0; highCycles = 0; maxWidth = 0;
  endtask

  task automatic idle(input int n);
    buttonIn = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tResetState();
    rstN = 1'b0; buttonIn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(pulseOut == 1'b0, "R1 output low in reset", pulseOut, 0);
    end
    buttonIn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    idle(3);
  endtask

  task automatic tLatency();
    logic s1, s2, s3;
    idle(2);
    buttonIn = 1'b1;                 // sampled at next rising edge (k)
    @(negedge clk); s1 = pulseOut;   // after edge k
    @(negedge clk); s2 = pulseOut;   // after edge k+1
    @(negedge clk); s3 = pulseOut;   // after edge k+2
    check(s1 == 1'b0, "R4 low after first sampling edge", s1, 0);
    check(s2 == 1'b1, "R4 high after second edge", s2, 1);
    check(s3 == 1'b0, "R3 low after third edge", s3, 0);
    idle(3);
  endtask

  task automatic tLongHold();
    clearCounts();
    buttonIn = 1'b1;
    for (int i = 0; i < 50; i++) @(negedge clk);
    idle(4);
    check(rises == 1, "R2 long hold pulse count", rises, 1);
    check(maxWidth == 1, "R3 long hold pulse width", maxWidth, 1);
  endtask

  task automatic tShortTap();
    clearCounts();
    buttonIn = 1'b1;
    @(negedge clk);
    idle(4);
    check(rises == 1, "R2 single-cycle tap pulse count", rises, 1);
    check(highCycles == 1, "R3 single-cycle tap high cycles", highCycles, 1);
  endtask

  task automatic tRepeatTaps();
    clearCounts();
    for (int i = 0; i < 5; i++) begin
      buttonIn = 1'b1; @(negedge clk);
      buttonIn = 1'b0; @(negedge clk);
    end
    idle(4);
    check(rises == 5, "R5 one-cycle gaps re-arm", rises, 5);
    check(highCycles == 5, "R3 repeated taps high cycles", highCycles, 5);
  endtask

  task automatic tUnsampledGlitch();
    clearCounts();
    buttonIn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #0.5 buttonIn = 1'b0;          // low only between edges
      #0.5 buttonIn = 1'b1;
    end
    idle(4);
    check(rises == 1, "R5 glitch between edges ignored", rises, 1);
  endtask

  task automatic tHeldThroughReset();
    @(negedge clk);
    rstN = 1'b0; buttonIn = 1'b1;
    @(negedge clk);
    clearCounts();
    rstN = 1'b1;
    for (int i = 0; i < 10; i++) @(negedge clk);
    idle(3);
    check(rises == 1, "R6 held press across reset release", rises, 1);
  endtask

  task automatic tAsyncClear();
    logic live;
    idle(2);
    buttonIn = 1'b1;
    @(negedge clk);
    @(negedge clk); live = pulseOut;
    check(live == 1'b1, "R7 pulse live before reset", live, 1);
    #0.5 rstN = 1'b0;
    #0.5;
    check(pulseOut == 1'b0, "R7 cleared without clock edge", pulseOut, 0);
    check(pulseOut == 1'b0, "R1 output low after async reset", pulseOut, 0);
    buttonIn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    idle(3);
  endtask

  initial begin
    tResetState();
    tLatency();
    tLongHold();
    tShortTap();
    tRepeatTaps();
    tUnsampledGlitch();
    tHeldThroughReset();
    tAsyncClear();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule